// File: doc/BRIEF.md
# Internal Clock Source Selector with Post-Divider

This block drives six internal clock outputs that feed fixed on-chip consumers. Each output picks one input from a pool of seven. The pool holds the auxiliary PLL and six frequency generator outputs. The output then divides the chosen input by a small factor that a 2-bit code selects through a lookup table. Every clock in the block is an enable strobe in one common system clock domain. An output emits one strobe every N strobes of its chosen source. It also carries a level that toggles once per output strobe.

All six outputs share one configuration register. Software writes it and reads it back through a simple port. Each output owns a 5-bit field, and a source code of zero switches that output off. A parameter selects the divider table variant. The extended variant turns one table entry into a divide-by-3. A new setting takes effect only when the current output period ends, so an output never emits a shortened period. Switching an output off takes effect at once.

Top module: `intclk_divmux`

## Requirements
- R1: A write stores bits 29:0 of the write data in the configuration register. A read returns those 30 bits, and bits 31:30 always read zero.
- R2: Output i is configured by register bits 5i+4 to 5i. Within that field, bits 4:2 are the source code and bits 1:0 are the divider code. Source code 1 selects the auxiliary PLL strobe, and codes 2 to 7 select generator strobes 0 to 5.
- R3: An output counts as enabled exactly when its source code is nonzero. While its source code is 0, the output emits no strobe and its toggle holds its value.
- R4: With the base table, divider codes 0, 1, 2 and 3 give divisors 1, 4, 1 and 2.
- R5: With the extended table, divider code 2 gives divisor 3. The other codes give the same divisors as the base table.
- R6: An output emits one strobe for every N strobes of its selected source, where N is the divisor. Only strobes of the selected source are counted. With divisor 1, the output strobe appears in the same cycle as the source strobe.
- R7: The toggle output flips in the cycle after each output strobe and stays unchanged otherwise.
- R8: A new nonzero configuration for an output is applied at the end of the period in progress. If no source strobe has been counted since the last output strobe, it is applied in the next cycle.
- R9: When the source code of an output is written to 0, output strobes stop from the cycle after the write. Any partly counted period is discarded.
- R10: When the selected source delivers no strobes, the output emits none, whatever the other pool inputs do.
- R11: A synchronous active-high reset clears the configuration register, all counters and all toggles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for the configuration register |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Configuration read-back, bits 31:30 are zero |
| pll_aux_tick | input | 1 | Auxiliary PLL enable strobe |
| fgen_tick | input | 6 | Frequency generator enable strobes 0 to 5 |
| out_tick | output | 6 | Divided output strobe per output |
| out_tgl | output | 6 | Level that toggles once per output strobe |

## Verification
A register write and a source strobe can arrive in the same cycle. The interesting cases are a write that turns an output off while a strobe would complete its period, and a write that changes the divisor partway through a counted period. The directed part of the bench builds both cases on purpose. The random part mixes writes at a low rate with dense source strobes, so the two events land together often. A cycle-level model built from the requirements predicts every output strobe, toggle and read-back value. It runs for a base-table instance and an extended-table instance at the same time.

// File: rtl/intclk_pkg.sv
package intclk_pkg;

    localparam int NUM_OUT = 6;
    localparam int NUM_GEN = 6;
    localparam int SRC_W   = 3;
    localparam int DV_W    = 2;
    localparam int FLD_W   = SRC_W + DV_W;
    localparam int REG_W   = 32;
    localparam int CFG_W   = NUM_OUT * FLD_W;
    localparam int CNT_W   = 3;

    typedef struct packed {
        logic [SRC_W-1:0] src;
        logic [DV_W-1:0]  dv;
    } fld_t;

    typedef enum logic {
        VAR_BASE = 1'b0,
        VAR_DIV3 = 1'b1
    } div_var_e;

    // Divider code to divisor. The table is deliberately non-monotonic.
    function automatic logic [CNT_W-1:0] div_of(input logic [DV_W-1:0] code,
                                                input div_var_e var_sel);
        logic [CNT_W-1:0] d;
        case (code)
            2'd0: d = 3'd1;
            2'd1: d = 3'd4;
            2'd2: d = (var_sel == VAR_DIV3) ? 3'd3 : 3'd1;
            default: d = 3'd2;
        endcase
        return d;
    endfunction

    function automatic logic fld_on(input fld_t f);
        return f.src != '0;
    endfunction

endpackage

// File: rtl/intclk_cfg_reg.sv
module intclk_cfg_reg
    import intclk_pkg::*;
#(
    parameter int N_OUT = NUM_OUT
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   we,
    input  logic [REG_W-1:0]       wdata,
    output logic [REG_W-1:0]       rdata,
    output fld_t [N_OUT-1:0]       fields
);
    localparam int USED_W = N_OUT * FLD_W;
    localparam int PAD_W  = REG_W - USED_W;

    logic [USED_W-1:0] cfg_q;
    logic [PAD_W-1:0]  unused_hi;

    assign unused_hi = wdata[REG_W-1:USED_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (we) begin
            cfg_q <= wdata[USED_W-1:0];
        end
    end

    assign rdata = {{PAD_W{1'b0}}, cfg_q};

    for (genvar i = 0; i < N_OUT; i++) begin : g_fld
        assign fields[i] = cfg_q[i*FLD_W +: FLD_W];
    end

endmodule

// File: rtl/intclk_src_pick.sv
module intclk_src_pick
    import intclk_pkg::*;
#(
    parameter int N_GEN = NUM_GEN
) (
    input  logic              aux_tick,
    input  logic [N_GEN-1:0]  gen_tick,
    input  logic [SRC_W-1:0]  code,
    output logic              tick
);
    localparam int POOL_W = N_GEN + 2;

    logic [POOL_W-1:0] pool;

    // Code 0 is the off position, code 1 the auxiliary PLL, then the generators.
    assign pool = {gen_tick, aux_tick, 1'b0};
    assign tick = pool[code];

endmodule

// File: rtl/intclk_post_div.sv
module intclk_post_div
    import intclk_pkg::*;
#(
    parameter int       N_GEN   = NUM_GEN,
    parameter div_var_e VARIANT = VAR_BASE
) (
    input  logic              clk,
    input  logic              rst,
    input  fld_t              want,
    input  logic              aux_tick,
    input  logic [N_GEN-1:0]  gen_tick,
    output logic              out_tick,
    output logic              out_tgl
);
    fld_t             act_q;
    logic [CNT_W-1:0] cnt_q;
    logic             tgl_q;
    logic             sel_tick;
    logic [CNT_W-1:0] dvsr;
    logic             want_on;
    logic             act_on;
    logic             fire;
    logic             load;

    intclk_src_pick #(.N_GEN(N_GEN)) pick_i (
        .aux_tick (aux_tick),
        .gen_tick (gen_tick),
        .code     (act_q.src),
        .tick     (sel_tick)
    );

    always_comb begin
        dvsr    = div_of(act_q.dv, VARIANT);
        want_on = fld_on(want);
        act_on  = fld_on(act_q);
        fire    = act_on && sel_tick && (cnt_q == dvsr - 3'd1);
        // Period boundary: a period ends now, or nothing has been counted yet.
        load    = fire || ((cnt_q == '0) && !sel_tick);
    end

    assign out_tick = fire && want_on;
    assign out_tgl  = tgl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q <= '0;
            cnt_q <= '0;
            tgl_q <= 1'b0;
        end else begin
            if (!want_on) begin
                act_q <= '0;
                cnt_q <= '0;
            end else begin
                if (load) begin
                    act_q <= want;
                end
                if (fire) begin
                    cnt_q <= '0;
                end else if (sel_tick && act_on) begin
                    cnt_q <= cnt_q + 3'd1;
                end
            end
            if (out_tick) begin
                tgl_q <= ~tgl_q;
            end
        end
    end

endmodule

// File: rtl/intclk_divmux.sv
module intclk_divmux
    import intclk_pkg::*;
#(
    parameter bit HAS_DIV3 = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic              pll_aux_tick,
    input  logic [5:0]        fgen_tick,
    output logic [5:0]        out_tick,
    output logic [5:0]        out_tgl
);
    localparam div_var_e VSEL = HAS_DIV3 ? VAR_DIV3 : VAR_BASE;

    fld_t [NUM_OUT-1:0] fields;

    intclk_cfg_reg #(.N_OUT(NUM_OUT)) cfg_i (
        .clk    (clk),
        .rst    (rst),
        .we     (cfg_we),
        .wdata  (cfg_wdata),
        .rdata  (cfg_rdata),
        .fields (fields)
    );

    for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
        intclk_post_div #(.N_GEN(NUM_GEN), .VARIANT(VSEL)) div_i (
            .clk      (clk),
            .rst      (rst),
            .want     (fields[i]),
            .aux_tick (pll_aux_tick),
            .gen_tick (fgen_tick),
            .out_tick (out_tick[i]),
            .out_tgl  (out_tgl[i])
        );
    end

endmodule

// File: rtl/intclk_divmux_chk.sv
module intclk_divmux_chk (
    input logic        clk,
    input logic        rst,
    input logic [31:0] cfg_rdata,
    input logic        pll_aux_tick,
    input logic [5:0]  fgen_tick,
    input logic [5:0]  out_tick,
    input logic [5:0]  out_tgl
);
    logic [5:0] en_mask;

    for (genvar i = 0; i < 6; i++) begin : g_en
        assign en_mask[i] = |cfg_rdata[i*5+2 +: 3];
    end

    // R1
    rd_pad_zero_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_rdata[31:30] == 2'b00);

    // R3
    off_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (out_tick & ~en_mask) == 6'd0);

    // R6
    tick_needs_src_chk: assert property (@(posedge clk) disable iff (rst)
        (|out_tick) |-> (pll_aux_tick || (|fgen_tick)));

    // R7
    tgl_follow_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (out_tgl == ($past(out_tgl) ^ $past(out_tick))));

    // R11
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (cfg_rdata == 32'd0 && out_tgl == 6'd0));

endmodule

bind intclk_divmux intclk_divmux_chk chk_i (
    .clk          (clk),
    .rst          (rst),
    .cfg_rdata    (cfg_rdata),
    .pll_aux_tick (pll_aux_tick),
    .fgen_tick    (fgen_tick),
    .out_tick     (out_tick),
    .out_tgl      (out_tgl)
);

// File: tb/intclk_divmux_tb_top.sv
`timescale 1ns/1ps
module intclk_divmux_tb_top;

    localparam int CLK_NS = 20;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic        aux = 1'b0;
    logic [5:0]  gen = '0;
    logic [31:0] rd_b, rd_x;
    logic [5:0]  tk_b, tk_x, tg_b, tg_x;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // model state, index 0 = base table, 1 = extended table
    logic [29:0] m_cfg;
    int m_src [2][6];
    int m_dv  [2][6];
    int m_cnt [2][6];
    bit m_tgl [2][6];
    int seen  [2][6];

    always #(CLK_NS/2) clk = ~clk;

    intclk_divmux #(.HAS_DIV3(1'b0)) dut_i (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(rd_b), .pll_aux_tick(aux), .fgen_tick(gen),
        .out_tick(tk_b), .out_tgl(tg_b));

    intclk_divmux #(.HAS_DIV3(1'b1)) dut_x (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(rd_x), .pll_aux_tick(aux), .fgen_tick(gen),
        .out_tick(tk_x), .out_tgl(tg_x));

    // R4 / R5 tables
    function automatic int exp_div(input int code, input int v);
        case (code)
            0: return 1;
            1: return 4;
            2: return (v == 1) ? 3 : 1;
            default: return 2;
        endcase
    endfunction

    // R2 pool order
    function automatic bit pool_tick(input int src, input bit a, input logic [5:0] g);
        if (src == 0) return 1'b0;
        if (src == 1) return a;
        return g[src-2];
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_cfg = '0;
        for (int v = 0; v < 2; v++)
            for (int c = 0; c < 6; c++) begin
                m_src[v][c] = 0; m_dv[v][c] = 0; m_cnt[v][c] = 0; m_tgl[v][c] = 0;
            end
    endtask

    task automatic clear_seen();
        for (int v = 0; v < 2; v++)
            for (int c = 0; c < 6; c++) seen[v][c] = 0;
    endtask

    task automatic step(input bit we, input logic [31:0] wd, input bit a, input logic [5:0] g);
        logic [5:0] e_tk [2];
        bit fire [2][6];
        bit sel [2][6];
        int wsrc, wdv;
        @(negedge clk);
        cfg_we = we; cfg_wdata = wd; aux = a; gen = g;
        #2;
        for (int v = 0; v < 2; v++) begin
            for (int c = 0; c < 6; c++) begin
                wsrc = int'(m_cfg[c*5+2 +: 3]);
                sel[v][c]  = pool_tick(m_src[v][c], a, g);
                fire[v][c] = (m_src[v][c] != 0) && sel[v][c] &&
                             (m_cnt[v][c] == exp_div(m_dv[v][c], v) - 1);
                e_tk[v][c] = fire[v][c] && (wsrc != 0);
            end
        end
        // R6 R8 R9 R10 per-cycle strobe check
        chk(tk_b == e_tk[0], "R6 base strobes", {26'd0, tk_b}, {26'd0, e_tk[0]});
        chk(tk_x == e_tk[1], "R6 ext strobes", {26'd0, tk_x}, {26'd0, e_tk[1]});
        for (int c = 0; c < 6; c++) begin
            seen[0][c] += int'(tk_b[c]);
            seen[1][c] += int'(tk_x[c]);
        end
        // model next state
        for (int v = 0; v < 2; v++) begin
            for (int c = 0; c < 6; c++) begin
                wsrc = int'(m_cfg[c*5+2 +: 3]);
                wdv  = int'(m_cfg[c*5 +: 2]);
                if (e_tk[v][c]) m_tgl[v][c] = ~m_tgl[v][c];
                if (wsrc == 0) begin
                    m_src[v][c] = 0; m_dv[v][c] = 0; m_cnt[v][c] = 0;
                end else begin
                    if (fire[v][c]) m_cnt[v][c] = 0;
                    else if (sel[v][c] && m_src[v][c] != 0) m_cnt[v][c]++;
                    if (fire[v][c] || (m_cnt[v][c] == 0 && !sel[v][c])) begin
                        m_src[v][c] = wsrc; m_dv[v][c] = wdv;
                    end
                end
            end
        end
        if (we) m_cfg = wd[29:0];
        @(posedge clk);
        #1;
        for (int c = 0; c < 6; c++) begin
            // R7
            chk(tg_b[c] == m_tgl[0][c], "R7 base toggle", {31'd0, tg_b[c]}, {31'd0, m_tgl[0][c]});
            chk(tg_x[c] == m_tgl[1][c], "R7 ext toggle", {31'd0, tg_x[c]}, {31'd0, m_tgl[1][c]});
        end
        // R1
        chk(rd_b == {2'b00, m_cfg}, "R1 readback", rd_b, {2'b00, m_cfg});
        chk(rd_x == {2'b00, m_cfg}, "R1 readback ext", rd_x, {2'b00, m_cfg});
    endtask

    task automatic wr(input logic [31:0] wd);
        step(1'b1, wd, 1'b0, 6'd0);
        step(1'b0, 32'd0, 1'b0, 6'd0);
    endtask

    task automatic pulses(input int n, input bit a, input logic [5:0] g);
        for (int k = 0; k < n; k++) step(1'b0, 32'd0, a, g);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; cfg_we = 1'b0; aux = 1'b0; gen = '0;
        repeat (2) @(posedge clk);
        #1;
        model_reset();
        // R11
        chk(rd_b == 32'd0 && rd_x == 32'd0, "R11 cfg cleared", rd_b | rd_x, 32'd0);
        chk(tg_b == 6'd0 && tg_x == 6'd0, "R11 toggles cleared", {26'd0, tg_b | tg_x}, 32'd0);
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        void'($urandom(32'h1C5A_0007));
        model_reset();
        do_reset();

        // R1: upper bits dropped
        wr(32'hFFFF_FFFF);
        chk(rd_b == 32'h3FFF_FFFF, "R1 pad bits", rd_b, 32'h3FFF_FFFF);
        wr(32'd0);

        // R2 R4 R5 R10: ch0 aux div code 2, ch1 gen5 div code 3
        wr(32'h0000_03E6);
        clear_seen();
        pulses(6, 1'b1, 6'd0);
        chk(seen[0][0] == 6, "R4 code2 base div1", seen[0][0], 6);
        chk(seen[1][0] == 2, "R5 code2 ext div3", seen[1][0], 2);
        chk(seen[0][1] == 0, "R10 ch1 idle on aux", seen[0][1], 0);
        clear_seen();
        pulses(4, 1'b0, 6'b10_0000);
        chk(seen[0][1] == 2 && seen[1][1] == 2, "R2 gen5 div2", seen[0][1], 2);
        chk(seen[0][0] == 0, "R10 ch0 idle on gen", seen[0][0], 0);
        clear_seen();
        pulses(4, 1'b0, 6'b01_1111);
        chk(seen[0][1] == 0, "R2 other gens ignored", seen[0][1], 0);

        // R8: divisor 4, two strobes, switch to divisor 1 mid-period
        wr(32'h0000_0005);
        clear_seen();
        pulses(2, 1'b1, 6'd0);
        wr(32'h0000_0004);
        pulses(1, 1'b1, 6'd0);
        chk(seen[0][0] == 0, "R8 old period kept", seen[0][0], 0);
        pulses(1, 1'b1, 6'd0);
        chk(seen[0][0] == 1, "R8 period end", seen[0][0], 1);
        pulses(1, 1'b1, 6'd0);
        chk(seen[0][0] == 2 && seen[1][0] == 2, "R8 new divisor", seen[0][0], 2);

        // R9 R3: disable discards partial count; disabled output silent
        wr(32'h0000_0005);
        pulses(3, 1'b1, 6'd0);
        step(1'b1, 32'd0, 1'b1, 6'd0);
        clear_seen();
        pulses(5, 1'b1, 6'd0);
        chk(seen[0][0] == 0 && seen[1][0] == 0, "R3 disabled silent", seen[0][0], 0);
        wr(32'h0000_0005);
        pulses(3, 1'b1, 6'd0);
        chk(seen[0][0] == 0, "R9 partial discarded", seen[0][0], 0);
        pulses(1, 1'b1, 6'd0);
        chk(seen[0][0] == 1, "R9 fresh period", seen[0][0], 1);

        // R6: divisor 1 strobe in same cycle, write coinciding with strobe
        wr(32'h0000_0004);
        step(1'b1, 32'd0, 1'b1, 6'd0);
        step(1'b0, 32'd0, 1'b1, 6'd0);

        // random phase
        for (int n = 0; n < 4000; n++) begin
            bit we;
            we = ($urandom_range(0, 19) == 0);
            step(we, $urandom(), $urandom_range(0, 1) == 1, 6'($urandom()));
        end

        do_reset();
        pulses(3, 1'b1, 6'h3F);
        chk(seen[0][0] >= 0 && tk_b == 6'd0, "R11 quiet after reset", {26'd0, tk_b}, 32'd0);

        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #(CLK_NS * 200000);
        if (!done) begin
            done = 1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule